// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the bus port of an x8 parallel flash and watches every write cycle. A write carries an address and a data byte, qualified by a one-cycle valid strobe. The decoder checks each write against the unlock prefixes that guard destructive operations. When a sequence completes it issues a single-cycle start pulse to the program or erase engine, together with the latched target address and data. It then holds busy until the operation timer reports that it has finished.

Byte program needs a three-write unlock followed by an address/data write. Both erase forms need a six-write double unlock, and the last write selects the whole array or a single 4 KB sector. The decoder also tracks an identification mode that replaces array data with fixed ID bytes at two read addresses. Any write that breaks a sequence drops the decoder back to read mode. While an operation runs, every write is ignored.

Top module: `flash_cmd_dec`

## Requirements
- R1: Out of reset, busy_o, id_mode_o, id_hit_o and all three start pulses are low.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by a fourth write of D@A, raise prog_start_o for the cycle after the fourth write, with op_addr_o=A and op_data_o=D.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h raise chip_start_o for the cycle after the sixth write.
- R4: The same five-write prefix followed by 30h at any address A raises sect_start_o, with sector_o = A[16:12] and op_addr_o = A.
- R5: Command address matching compares only address bits 15..0, so bit 16 may take either value during a sequence.
- R6: A write whose address or data does not match the expected step returns the decoder to its idle state, so the remaining writes of the broken sequence start nothing.
- R7: From a start pulse until op_done_i is seen, busy_o stays high and writes are ignored: they neither launch an operation nor advance the sequence.
- R8: busy_o falls on the clock edge at which op_done_i is high while busy.
- R9: AAh@5555h, 55h@2AAAh, 90h@5555h sets id_mode_o. In that mode a read of full address 00000h returns id_hit_o=1 with id_data_o=7Fh, 00001h returns A8h, and any other address gives id_hit_o=0.
- R10: A single write of F0h to any address clears id_mode_o.
- R11: The unlock pair followed by F0h@5555h also leaves ID mode.
- R12: Every start pulse lasts exactly one cycle, and at most one of the three is high at a time.
- R13: A sixth write of 10h to an address other than 5555h starts no operation and aborts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address for the ID remap |
| op_done_i | input | 1 | Operation finished, from the timer |
| prog_start_o | output | 1 | Byte program start pulse |
| sect_start_o | output | 1 | Sector erase start pulse |
| chip_start_o | output | 1 | Chip erase start pulse |
| op_addr_o | output | ADDR_W | Latched target address |
| op_data_o | output | 8 | Latched program data |
| sector_o | output | ADDR_W-SECT_LSB | Latched sector index |
| busy_o | output | 1 | Operation in progress |
| id_mode_o | output | 1 | ID read mode active |
| id_hit_o | output | 1 | Read address hits an ID location |
| id_data_o | output | 8 | ID byte for the read address |

## Verification
The bench builds the block with the default ADDR_W=17 and SECT_LSB=12. This gives one address bit above the 16 compared bits, so sequences can be driven with bit 16 set to show it is ignored. The ID read check at 10001h shows the same bit is decoded for ID reads. The 5-bit sector field lets a sector erase at 1B123h check that the index is taken from the top five address bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_W = 16;

  localparam logic [CMD_W-1:0] A_KEY1 = 16'h5555;
  localparam logic [CMD_W-1:0] A_KEY2 = 16'h2AAA;

  localparam logic [7:0] D_KEY1  = 8'hAA;
  localparam logic [7:0] D_KEY2  = 8'h55;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_ERASE = 8'h80;
  localparam logic [7:0] D_IDENT = 8'h90;
  localparam logic [7:0] D_EXIT  = 8'hF0;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;

  localparam logic [7:0] ID_MFR = 8'h7F;
  localparam logic [7:0] ID_DEV = 8'hA8;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS3, SQ_ERS4, SQ_ERS5
  } seq_e;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_e;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [CMD_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             busy_i,
  output op_e              op_o,
  output logic             id_mode_o
);
  seq_e st_q, st_d;
  logic id_q, id_set, id_clr;
  logic at_k1, at_k2;

  assign at_k1 = (wr_addr_i == A_KEY1);
  assign at_k2 = (wr_addr_i == A_KEY2);

  always_comb begin
    st_d   = st_q;
    op_o   = OP_NONE;
    id_set = 1'b0;
    id_clr = 1'b0;
    if (wr_valid_i && !busy_i) begin
      st_d = SQ_IDLE;
      if (wr_data_i == D_EXIT && st_q != SQ_PROG) id_clr = 1'b1;
      case (st_q)
        SQ_IDLE: if (at_k1 && wr_data_i == D_KEY1) st_d = SQ_UNL1;
        SQ_UNL1: if (at_k2 && wr_data_i == D_KEY2) st_d = SQ_UNL2;
        SQ_UNL2: if (at_k1) begin
          if (wr_data_i == D_PROG)       st_d = SQ_PROG;
          else if (wr_data_i == D_ERASE) st_d = SQ_ERS3;
          else if (wr_data_i == D_IDENT) id_set = 1'b1;
        end
        SQ_PROG: op_o = OP_PROG;
        SQ_ERS3: if (at_k1 && wr_data_i == D_KEY1) st_d = SQ_ERS4;
        SQ_ERS4: if (at_k2 && wr_data_i == D_KEY2) st_d = SQ_ERS5;
        SQ_ERS5: begin
          if (at_k1 && wr_data_i == D_CHIP) op_o = OP_CHIP;
          else if (wr_data_i == D_SECT)     op_o = OP_SECT;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE;
      id_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (id_set)      id_q <= 1'b1;
      else if (id_clr) id_q <= 1'b0;
    end
  end

  assign id_mode_o = id_q;
endmodule

// File: rtl/fcd_launch.sv
module fcd_launch
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECT_LSB = 12,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              op_done_i,
  output logic [2:0]        start_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic [SECT_W-1:0] sector_o
);
  logic [2:0] req;
  logic       busy_q;

  assign req = {op_i == OP_CHIP, op_i == OP_SECT, op_i == OP_PROG};

  for (genvar i = 0; i < 3; i++) begin : g_pulse
    logic p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= 1'b0;
      else         p_q <= req[i];
    end
    assign start_o[i] = p_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      op_addr_o <= '0;
      op_data_o <= '0;
      sector_o  <= '0;
    end else if (op_i != OP_NONE) begin
      busy_q    <= 1'b1;
      op_addr_o <= wr_addr_i;
      op_data_o <= wr_data_i;
      sector_o  <= wr_addr_i[ADDR_W-1:SECT_LSB];
    end else if (busy_q && op_done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/fcd_id_map.sv
module fcd_id_map
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              id_hit_o,
  output logic [7:0]        id_data_o
);
  logic hi_zero;
  assign hi_zero = (rd_addr_i[ADDR_W-1:1] == '0);

  always_comb begin
    id_hit_o  = id_mode_i && hi_zero;
    id_data_o = 8'h00;
    if (id_hit_o) id_data_o = rd_addr_i[0] ? ID_DEV : ID_MFR;
  end
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECT_LSB = 12,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              op_done_i,
  output logic              prog_start_o,
  output logic              sect_start_o,
  output logic              chip_start_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              busy_o,
  output logic              id_mode_o,
  output logic              id_hit_o,
  output logic [7:0]        id_data_o
);
  op_e        op;
  logic [2:0] start;

  fcd_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(wr_valid_i),
    .wr_addr_i (wr_addr_i[CMD_W-1:0]),
    .wr_data_i (wr_data_i),
    .busy_i    (busy_o),
    .op_o      (op),
    .id_mode_o (id_mode_o)
  );

  fcd_launch #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .op_done_i(op_done_i),
    .start_o  (start),
    .busy_o   (busy_o),
    .op_addr_o(op_addr_o),
    .op_data_o(op_data_o),
    .sector_o (sector_o)
  );

  fcd_id_map #(.ADDR_W(ADDR_W)) u_id (
    .id_mode_i(id_mode_o),
    .rd_addr_i(rd_addr_i),
    .id_hit_o (id_hit_o),
    .id_data_o(id_data_o)
  );

  assign prog_start_o = start[0];
  assign sect_start_o = start[1];
  assign chip_start_o = start[2];
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [7:0]        wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              op_done_i,
  input logic              prog_start_o,
  input logic              sect_start_o,
  input logic              chip_start_o,
  input logic              busy_o,
  input logic              id_mode_o,
  input logic              id_hit_o,
  input logic [7:0]        id_data_o
);
  logic any_start;
  assign any_start = prog_start_o | sect_start_o | chip_start_o;

  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, sect_start_o, chip_start_o})); // R12
  AST_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_start |=> !any_start); // R12
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_start |-> busy_o); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !any_start); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !op_done_i) |=> busy_o); // R7
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_done_i) |=> !busy_o); // R8
  AST_ID_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !busy_o && wr_data_i == 8'hF0 && !any_start && id_mode_o && $past(!busy_o))
      |=> !id_mode_o || any_start); // R10
  AST_ID_MFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_o && rd_addr_i == '0) |-> (id_hit_o && id_data_o == 8'h7F)); // R9
  AST_ID_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> !id_hit_o); // R9
endmodule

bind flash_cmd_dec fcd_chk #(.ADDR_W(ADDR_W)) u_fcd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_data_i   (wr_data_i),
  .rd_addr_i   (rd_addr_i),
  .op_done_i   (op_done_i),
  .prog_start_o(prog_start_o),
  .sect_start_o(sect_start_o),
  .chip_start_o(chip_start_o),
  .busy_o      (busy_o),
  .id_mode_o   (id_mode_o),
  .id_hit_o    (id_hit_o),
  .id_data_o   (id_data_o)
);

// File: tb/flash_cmd_dec_test.sv
module flash_cmd_dec_test;
  localparam int ADDR_W = 17;
  localparam int SECT_LSB = 12;
  localparam int NV = 31;

  typedef struct packed {
    logic [16:0] a;
    logic [7:0]  d;
    logic [1:0]  k;   // 0 none, 1 program, 2 sector, 3 chip
    logic [3:0]  r;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R2 program
    '{17'h05555, 8'hAA, 2'd0, 4'd2}, '{17'h02AAA, 8'h55, 2'd0, 4'd2},
    '{17'h05555, 8'hA0, 2'd0, 4'd2}, '{17'h01234, 8'h5A, 2'd1, 4'd2},
    // R5 bit 16 set on command writes
    '{17'h15555, 8'hAA, 2'd0, 4'd5}, '{17'h12AAA, 8'h55, 2'd0, 4'd5},
    '{17'h15555, 8'hA0, 2'd0, 4'd5}, '{17'h1FFFF, 8'h00, 2'd1, 4'd5},
    // R3 chip erase
    '{17'h05555, 8'hAA, 2'd0, 4'd3}, '{17'h02AAA, 8'h55, 2'd0, 4'd3},
    '{17'h05555, 8'h80, 2'd0, 4'd3}, '{17'h05555, 8'hAA, 2'd0, 4'd3},
    '{17'h02AAA, 8'h55, 2'd0, 4'd3}, '{17'h05555, 8'h10, 2'd3, 4'd3},
    // R4 sector erase
    '{17'h05555, 8'hAA, 2'd0, 4'd4}, '{17'h02AAA, 8'h55, 2'd0, 4'd4},
    '{17'h05555, 8'h80, 2'd0, 4'd4}, '{17'h05555, 8'hAA, 2'd0, 4'd4},
    '{17'h02AAA, 8'h55, 2'd0, 4'd4}, '{17'h1B123, 8'h30, 2'd2, 4'd4},
    // R6 broken unlock
    '{17'h05555, 8'hAA, 2'd0, 4'd6}, '{17'h02AAA, 8'h56, 2'd0, 4'd6},
    '{17'h05555, 8'hA0, 2'd0, 4'd6}, '{17'h01234, 8'h77, 2'd0, 4'd6},
    // R13 chip code at wrong address
    '{17'h05555, 8'hAA, 2'd0, 4'd13}, '{17'h02AAA, 8'h55, 2'd0, 4'd13},
    '{17'h05555, 8'h80, 2'd0, 4'd13}, '{17'h05555, 8'hAA, 2'd0, 4'd13},
    '{17'h02AAA, 8'h55, 2'd0, 4'd13}, '{17'h04444, 8'h10, 2'd0, 4'd13},
    '{17'h05555, 8'h10, 2'd0, 4'd13}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic op_done = 1'b0;
  logic prog_s, sect_s, chip_s, busy, id_mode, id_hit;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0] op_data, id_data;
  logic [ADDR_W-SECT_LSB-1:0] sector;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_dec #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .op_done_i(op_done),
    .prog_start_o(prog_s), .sect_start_o(sect_s), .chip_start_o(chip_s),
    .op_addr_o(op_addr), .op_data_o(op_data), .sector_o(sector),
    .busy_o(busy), .id_mode_o(id_mode), .id_hit_o(id_hit), .id_data_o(id_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, return at the following negedge with results settled
  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk(busy == 1'b0, "R8 busy clear", busy, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] kind;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, id_mode, id_hit, prog_s, sect_s, chip_s} == 6'b0, "R1 reset",
        {busy, id_mode, id_hit, prog_s, sect_s, chip_s}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, id_mode, prog_s, sect_s, chip_s} == 5'b0, "R1 after release",
        {busy, id_mode, prog_s, sect_s, chip_s}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d);
      kind = {chip_s, sect_s, prog_s};
      case (VECS[i].k)
        2'd1: chk(kind == 3'b001, $sformatf("R%0d start", VECS[i].r), kind, 3'b001);
        2'd2: chk(kind == 3'b010, $sformatf("R%0d start", VECS[i].r), kind, 3'b010);
        2'd3: chk(kind == 3'b100, $sformatf("R%0d start", VECS[i].r), kind, 3'b100);
        default: chk(kind == 3'b000, $sformatf("R%0d no start", VECS[i].r), kind, 0);
      endcase
      if (VECS[i].k != 2'd0) begin
        chk(busy, $sformatf("R%0d busy", VECS[i].r), busy, 1);
        if (VECS[i].k == 2'd1) begin
          chk(op_addr == VECS[i].a, $sformatf("R%0d addr", VECS[i].r), op_addr, VECS[i].a);
          chk(op_data == VECS[i].d, $sformatf("R%0d data", VECS[i].r), op_data, VECS[i].d);
        end
        if (VECS[i].k == 2'd2)
          chk(sector == VECS[i].a[16:12], "R4 sector", sector, VECS[i].a[16:12]);
        @(negedge clk);
        chk({chip_s, sect_s, prog_s} == 3'b0, "R12 single cycle", {chip_s, sect_s, prog_s}, 0);
        finish_op();
      end
    end

    // R7 writes ignored while busy
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    wr(17'h00042, 8'h11);
    chk(prog_s, "R7 setup start", prog_s, 1);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    wr(17'h00077, 8'h22);
    chk({chip_s, sect_s, prog_s} == 3'b0, "R7 no start while busy", {chip_s, sect_s, prog_s}, 0);
    chk(busy, "R7 busy held", busy, 1);
    chk(op_addr == 17'h00042, "R7 addr kept", op_addr, 17'h00042);
    finish_op();
    wr(17'h00100, 8'h33);
    chk(prog_s == 1'b0, "R7 sequence not advanced", prog_s, 0);

    // R9 ID entry and remap
    rd_addr = 17'h00000;
    #1 chk(id_hit == 1'b0, "R9 no hit outside id", id_hit, 0);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    chk(id_mode, "R9 entry", id_mode, 1);
    rd_addr = 17'h00000;
    #1 chk(id_hit && id_data == 8'h7F, "R9 mfr byte", {id_hit, id_data}, 9'h17F);
    rd_addr = 17'h00001;
    #1 chk(id_hit && id_data == 8'hA8, "R9 dev byte", {id_hit, id_data}, 9'h1A8);
    rd_addr = 17'h00002;
    #1 chk(!id_hit, "R9 other addr", id_hit, 0);
    rd_addr = 17'h10001;
    #1 chk(!id_hit, "R9 high addr", id_hit, 0);

    // R10 single exit write
    wr(17'h03333, 8'hF0);
    chk(!id_mode, "R10 exit", id_mode, 0);

    // R11 unlocked exit
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
    chk(id_mode, "R11 still in id", id_mode, 1);
    wr(17'h05555, 8'hF0);
    chk(!id_mode, "R11 exit", id_mode, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule